// File: doc/BRIEF.md
# Multiphase PWM Slot Sequencer

This block paces a multiphase switching regulator with one to four phases. A free-running counter divides each switching period into equal slots, one for each active phase. When the counter reaches a phase's slot offset, that phase gets a one-cycle start pulse, which the downstream PWM logic uses to begin a new switching cycle. A phase that is not fitted is marked by its disable flag, for example because its current-sense pair is tied to the supply. Such a phase receives no pulses, and the phases that remain are spread evenly over the period.

The phase count and the period length are captured while reset is held. From these two values the slot offsets are computed into registers, so the per-cycle path only compares the counter against stored values. A gate-enable input silences every start pulse without stopping the counter, so the slot timing stays in step when the gate is opened again.

Top module: `mph_slot_sequencer`

## Requirements
- R1: The active count N is the bit index of the lowest set flag in `phase_off[NPH-1:1]`, or NPH when none of them is set. `phase_off[0]` is ignored, so N is at least 1. Any flag above the first set one is also ignored. `active_cnt` shows N.
- R2: Active phase k (0-based, k < N) has slot offset floor(P*k/N), where P is the captured period. With P=100 and N=4 this gives 0, 25, 50, 75. With P=120 and N=3 it gives 0, 40, 80.
- R3: The slot counter counts 0 to P-1 and then wraps, so each active phase pulses exactly once every P clock cycles. P must be at least NPH.
- R4: Start pulses are registered and last one clock cycle. Counting the first rising edge with reset low as edge 1, bit k of `start_pulse` is high after edge j exactly when (j-1) mod P equals phase k's offset and `gate_en` was high at edge j.
- R5: `phase_off` and `period_len` are sampled only while `rst` is high, which must last at least one cycle. Changes to them after reset is released have no effect on pulses or on `active_cnt`.
- R6: A phase with index N or higher keeps its start pulse at 0.
- R7: While `gate_en` is low, all start pulses are 0 and the slot counter keeps running. After the gate is released, pulses resume at the same slot positions they would have had without the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; phase count and period are captured while it is high |
| period_len | input | CW | Switching period in clock cycles |
| phase_off | input | NPH | Per-phase disable flags, bit k for phase k |
| gate_en | input | 1 | When low, all start pulses are suppressed |
| start_pulse | output | NPH | One-cycle start pulse for each phase |
| active_cnt | output | CNTW | Detected number of active phases |

## Verification
A wrong captured count shows in `active_cnt` in the very first cycle after reset. Within one period it also shows as pulses that are missing, misplaced or extra. A corrupted offset register or a wrong wrap point moves a pulse away from its expected cycle the first time that slot comes round, so any error appears within P+1 cycles of reset release. Because the bench compares every output bit in every cycle against a reference model of slot arithmetic, even a one-cycle shift caused by gate handling or counter restart is caught at the edge where it first occurs.

// File: rtl/mph_seq_pkg.sv
package mph_seq_pkg;

  // Number of leading active phases: lowest set flag index among bits 1..nph-1,
  // or nph when none is set. Bit 0 never disables.
  function automatic int lead_active(input logic [31:0] flags, input int nph);
    int n;
    n = nph;
    for (int i = nph - 1; i >= 1; i--) begin
      if (flags[i]) n = i;
    end
    return n;
  endfunction

endpackage

// File: rtl/mph_phase_count.sv
module mph_phase_count #(
  parameter int NPH  = 4,
  parameter int CNTW = $clog2(NPH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPH-1:0]  phase_off,
  output logic [CNTW-1:0] cnt_now,
  output logic [CNTW-1:0] cnt_q
);
  import mph_seq_pkg::*;

  logic [31:0] flags_ext;

  always_comb begin
    flags_ext = '0;
    flags_ext[NPH-1:0] = phase_off;
    cnt_now = CNTW'(lead_active(flags_ext, NPH));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= cnt_now;
  end

  // R1: count always in 1..NPH
  p_count_range_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= CNTW'(1)) && (cnt_q <= CNTW'(NPH)));

  // R5: count held after reset release
  p_count_hold_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(cnt_q));

endmodule

// File: rtl/mph_slot_counter.sv
module mph_slot_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_len,
  output logic [CW-1:0] slot_q,
  output logic [CW-1:0] per_q
);
  logic [CW:0] slot_inc;

  assign slot_inc = {1'b0, slot_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q  <= period_len;
      slot_q <= '0;
    end else if (slot_inc >= {1'b0, per_q}) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_inc[CW-1:0];
    end
  end

  // R3: counter stays inside the period
  p_slot_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    (per_q != '0) |-> (slot_q < per_q));

  // R3: counter wraps to zero from the last slot
  p_slot_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (slot_inc == {1'b0, per_q}) |=> (slot_q == '0));

  // R5: period held after reset release
  p_period_hold_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(per_q));

endmodule

// File: rtl/mph_offset_table.sv
module mph_offset_table #(
  parameter int NPH  = 4,
  parameter int CW   = 16,
  parameter int CNTW = $clog2(NPH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CW-1:0]      period_len,
  input  logic [CNTW-1:0]    cnt_now,
  output logic [NPH*CW-1:0]  offs_q
);
  localparam int PW = CW + CNTW;

  for (genvar k = 0; k < NPH; k++) begin : g_slot
    logic [PW-1:0] prod;
    logic [PW-1:0] quo;

    always_comb begin
      prod = PW'(period_len) * PW'(k);
      quo  = '0;
      for (int d = 1; d <= NPH; d++) begin
        if (cnt_now == CNTW'(d)) quo = prod / PW'(d);
      end
    end

    always_ff @(posedge clk) begin
      if (rst) offs_q[k*CW +: CW] <= quo[CW-1:0];
    end

    // R5: offsets frozen after reset release
    p_offset_hold_r5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> $stable(offs_q[k*CW +: CW]));
  end

  // R2: phase 0 always starts at slot zero
  p_first_offset_r2: assert property (@(posedge clk) disable iff (rst)
    offs_q[CW-1:0] == '0);

endmodule

// File: rtl/mph_slot_sequencer.sv
module mph_slot_sequencer #(
  parameter int NPH  = 4,
  parameter int CW   = 16,
  parameter int CNTW = $clog2(NPH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   period_len,
  input  logic [NPH-1:0]  phase_off,
  input  logic            gate_en,
  output logic [NPH-1:0]  start_pulse,
  output logic [CNTW-1:0] active_cnt
);
  logic [CNTW-1:0]   cnt_now;
  logic [CNTW-1:0]   cnt_q;
  logic [CW-1:0]     slot_q;
  logic [CW-1:0]     per_q;
  logic [NPH*CW-1:0] offs_q;

  mph_phase_count #(.NPH(NPH), .CNTW(CNTW)) u_count (
    .clk(clk), .rst(rst), .phase_off(phase_off),
    .cnt_now(cnt_now), .cnt_q(cnt_q)
  );

  mph_slot_counter #(.CW(CW)) u_slot (
    .clk(clk), .rst(rst), .period_len(period_len),
    .slot_q(slot_q), .per_q(per_q)
  );

  mph_offset_table #(.NPH(NPH), .CW(CW), .CNTW(CNTW)) u_offs (
    .clk(clk), .rst(rst), .period_len(period_len),
    .cnt_now(cnt_now), .offs_q(offs_q)
  );

  assign active_cnt = cnt_q;

  for (genvar k = 0; k < NPH; k++) begin : g_pulse
    logic live;
    assign live = (CNTW'(k) < cnt_q);

    always_ff @(posedge clk) begin
      if (rst) start_pulse[k] <= 1'b0;
      else     start_pulse[k] <= gate_en && live && (slot_q == offs_q[k*CW +: CW]);
    end

    // R6: phases beyond the active count stay silent
    p_idle_phase_r6: assert property (@(posedge clk) disable iff (rst)
      (CNTW'(k) >= active_cnt) |-> !start_pulse[k]);

    // R4: a pulse lasts a single cycle when the period exceeds one slot
    p_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
      (start_pulse[k] && per_q > CW'(1)) |=> !start_pulse[k]);
  end

  // R7: gate low at an edge gives no pulse after it
  p_gate_mute_r7: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> (start_pulse == '0));

  // R2: distinct slots give at most one pulse per cycle
  p_single_phase_r2: assert property (@(posedge clk) disable iff (rst)
    (per_q >= CW'(NPH)) |-> $onehot0(start_pulse));

endmodule

// File: tb/mph_slot_sequencer_tb_top.sv
module mph_slot_sequencer_tb_top;
  localparam int NPH  = 4;
  localparam int CW   = 16;
  localparam int CNTW = $clog2(NPH + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [CW-1:0]   period_len = 16'd100;
  logic [NPH-1:0]  phase_off = '0;
  logic            gate_en = 1'b1;
  logic [NPH-1:0]  start_pulse;
  logic [CNTW-1:0] active_cnt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mph_slot_sequencer #(.NPH(NPH), .CW(CW), .CNTW(CNTW)) dut_i (
    .clk(clk), .rst(rst), .period_len(period_len), .phase_off(phase_off),
    .gate_en(gate_en), .start_pulse(start_pulse), .active_cnt(active_cnt)
  );

  function automatic int exp_count(input logic [NPH-1:0] f);
    int n = NPH;
    for (int i = NPH - 1; i >= 1; i--) if (f[i]) n = i;
    return n;
  endfunction

  function automatic logic [NPH-1:0] exp_pulses(input int n, input int p, input int j, input logic g);
    logic [NPH-1:0] v = '0;
    for (int k = 0; k < NPH; k++)
      if (g && k < n && ((j - 1) % p) == (p * k) / n) v[k] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  // gmode: 0 always on, 1 random, 2 off for a window; scr: scramble inputs after reset
  task automatic run_cfg(input string req, input logic [NPH-1:0] f, input int p,
                         input int cycles, input int gmode, input bit scr);
    int n;
    logic g;
    @(negedge clk);
    rst = 1'b1; phase_off = f; period_len = CW'(p); gate_en = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    n = exp_count(f);
    for (int j = 1; j <= cycles; j++) begin
      case (gmode)
        1: g = ($urandom % 4) != 0;
        2: g = !(j > p / 2 && j < p + p / 2);
        default: g = 1'b1;
      endcase
      gate_en = g;
      if (scr) begin
        phase_off = NPH'($urandom);
        period_len = CW'($urandom % 500 + 4);
      end
      @(posedge clk);
      @(negedge clk);
      if (j == 1) chk({req, " R1 count"}, int'(active_cnt), n);
      chk({req, " pulses"}, int'(start_pulse), int'(exp_pulses(n, p, j, g)));
    end
    chk({req, " R5 count held"}, int'(active_cnt), n);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    @(negedge clk);
    chk("R4 reset pulses", int'(start_pulse), 0);
    run_cfg("R2 R3 four phase", 4'b0000, 100, 320, 0, 0);
    run_cfg("R2 three phase", 4'b1000, 120, 260, 0, 0);
    run_cfg("R1 phase0 flag ignored", 4'b0011, 50, 120, 0, 0);
    run_cfg("R6 upper flag ignored", 4'b1101, 40, 90, 0, 0);
    run_cfg("R1 R6 two phase", 4'b0100, 64, 140, 0, 0);
    run_cfg("R7 gate window", 4'b0000, 37, 160, 2, 0);
    run_cfg("R7 random gate", 4'b0000, 41, 200, 1, 0);
    run_cfg("R5 inputs scrambled", 4'b1000, 33, 150, 0, 1);
    run_cfg("R4 minimum period", 4'b0000, 4, 24, 0, 0);
    for (int r = 0; r < 6; r++)
      run_cfg("R3 random cfg", NPH'($urandom), int'($urandom % 200) + NPH,
              250, 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule